// File: doc/BRIEF.md
# Freezable Control Register Bank

This block holds a small set of byte-wide control registers that a serial control-port front end fills through a parallel write port. That port carries an address, a data byte and a one-cycle write strobe. Each register has two copies. The staging copy takes every write and is what readback returns. The live copy drives the block's outputs. One register, the miscellaneous control byte, carries a freeze flag. While the flag is clear, a write reaches the live copy on the same clock edge. While it is set, the live copy holds its value, and every staged change moves across together on the edge that clears the flag.

The miscellaneous control byte is also decoded into device-level signals. These are a low-power request, a control-port mode flag and a master-clock prescale selection. The low-power request is gated by the control-port mode flag, so a part left in stand-alone mode never powers down. The freeze flag, the mode flag and the power-down bit never wait on freeze, so software cannot lock itself out. A one-cycle pulse marks every change of the live prescale selection.

Top module: `ctlbank_top`

## Requirements
- R1: After reset, the miscellaneous control byte (address 0) reads 8'h80 and every other register reads 8'h00. `low_power` is 0, `cp_mode` is 0 and `prescale_div` is 1.
- R2: While the staged freeze bit (bit 5 of address 0) is 0 after a write, the written byte appears in its slice of `ctl_q` (register n at bits 8n+7:8n) at the next clock edge.
- R3: While freeze stays 1, the live copy keeps its contents for all registers other than address 0 and for bits 4 and 3 of address 0, whatever is written.
- R4: `rd_data` returns the staged contents of the register selected by `rd_addr`, including writes still held by freeze.
- R5: On the clock edge where a write clears the freeze bit, all staged contents are copied to the live copy together.
- R6: Bits 7 (power-down), 6 (control-port enable) and 5 (freeze) of address 0 reach the live copy at the next edge even while freeze is 1.
- R7: `cp_mode` equals live bit 6. `low_power` is 1 exactly when live bits 7 and 6 are both 1, and register contents are kept while it is 1.
- R8: `prescale_div` is a binary divide value: 1 when live bits 4 and 3 are both 0, 2 when only bit 4 is set, 3 when only bit 3 is set, and 6 when both are set.
- R9: `prescale_chg` is 1 for exactly the one cycle after the edge on which `prescale_div` changes, and 0 otherwise.
- R10: Bits 2 to 0 of address 0 ignore writes and always read back as 0.
- R11: Writes to addresses at or above the number of registers (4 by default) change no register, and reads of those addresses return 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| wr_addr | input | ADDR_W (3) | Write register address |
| wr_data | input | 8 | Write data byte |
| rd_addr | input | ADDR_W (3) | Readback register address |
| rd_data | output | 8 | Staged contents of the addressed register |
| ctl_q | output | NUM_REGS*8 (32) | Live copies of all registers, register n in bits 8n+7:8n |
| low_power | output | 1 | Low-power request, gated by control-port mode |
| cp_mode | output | 1 | Control-port mode is enabled |
| prescale_div | output | 3 | Selected master-clock divide value (1, 2, 3 or 6) |
| prescale_chg | output | 1 | One-cycle pulse after the prescale selection changes |

## Verification
The hardest state to reach is a frozen window in which the staged and live copies disagree on several registers at once. The release then has to move everything across in one edge while the prescale selection changes and the power-down bit toggles. A directed sequence builds this window on purpose. It sets freeze, stages a general register together with both divide bits, raises power-down while still frozen, and then clears freeze. The random phase weights writes toward address 0, so freeze opens and closes often and writes land in both staging and live copies on many cycles.

// File: rtl/ctlbank_pkg.sv
package ctlbank_pkg;
   localparam int BYTE_W   = 8;
   localparam int PRESC_W  = 3;
   localparam int PDN_BIT  = 7;
   localparam int CPEN_BIT = 6;
   localparam int FRZ_BIT  = 5;
   localparam int DIV2_BIT = 4;
   localparam int DIV3_BIT = 3;

   localparam logic [BYTE_W-1:0] MISC_RESET     = 8'h80;
   localparam logic [BYTE_W-1:0] MISC_WR_MASK   = 8'hF8;
   localparam logic [BYTE_W-1:0] MISC_HOLD_MASK = 8'h18;
   localparam logic [BYTE_W-1:0] GEN_WR_MASK    = 8'hFF;
   localparam logic [BYTE_W-1:0] GEN_HOLD_MASK  = 8'hFF;

   function automatic logic [PRESC_W-1:0] presc_code(input logic by2, input logic by3);
      unique case ({by2, by3})
         2'b00:   return 3'd1;
         2'b10:   return 3'd2;
         2'b01:   return 3'd3;
         default: return 3'd6;
      endcase
   endfunction
endpackage

// File: rtl/ctlbank_regfile.sv
module ctlbank_regfile import ctlbank_pkg::*; #(
   parameter int NUM_REGS  = 4,
   parameter int ADDR_W    = 3,
   parameter int MISC_ADDR = 0
)(
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [ADDR_W-1:0]          wr_addr,
   input  logic [BYTE_W-1:0]          wr_data,
   output logic [NUM_REGS*BYTE_W-1:0] shd_flat,
   output logic [NUM_REGS*BYTE_W-1:0] act_flat
);
   logic [BYTE_W-1:0] shd_q   [NUM_REGS];
   logic [BYTE_W-1:0] shd_nxt [NUM_REGS];
   logic [BYTE_W-1:0] act_q   [NUM_REGS];
   logic [BYTE_W-1:0] act_nxt [NUM_REGS];
   logic misc_hit;
   logic frz_nxt;
   logic act_frz;

   assign misc_hit = wr_en && (wr_addr == ADDR_W'(MISC_ADDR));
   assign frz_nxt  = misc_hit ? wr_data[FRZ_BIT] : shd_q[MISC_ADDR][FRZ_BIT];
   assign act_frz  = act_q[MISC_ADDR][FRZ_BIT];

   for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
      localparam logic [BYTE_W-1:0] RST_V = (g == MISC_ADDR) ? MISC_RESET     : '0;
      localparam logic [BYTE_W-1:0] WMASK = (g == MISC_ADDR) ? MISC_WR_MASK   : GEN_WR_MASK;
      localparam logic [BYTE_W-1:0] HMASK = (g == MISC_ADDR) ? MISC_HOLD_MASK : GEN_HOLD_MASK;
      logic hit;

      assign hit        = wr_en && (wr_addr == ADDR_W'(g));
      assign shd_nxt[g] = hit ? (wr_data & WMASK) : shd_q[g];
      assign act_nxt[g] = frz_nxt ? ((act_q[g] & HMASK) | (shd_nxt[g] & ~HMASK))
                                  : shd_nxt[g];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            shd_q[g] <= RST_V;
            act_q[g] <= RST_V;
         end else begin
            shd_q[g] <= shd_nxt[g];
            act_q[g] <= act_nxt[g];
         end
      end

      assign shd_flat[g*BYTE_W +: BYTE_W] = shd_q[g];
      assign act_flat[g*BYTE_W +: BYTE_W] = act_q[g];

      // R3: freezable bits of the live copy stay put while freeze remains set
      assert_freeze_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
         act_frz |=> (!act_frz || $stable(act_q[g] & HMASK)));
   end

   // R2 / R5: with freeze clear the live copy mirrors the staged copy
   assert_unfrozen_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !act_frz |-> (act_flat == shd_flat));

   // R6: freeze, enable and power-down bits are never held
   assert_immediate_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
      act_q[MISC_ADDR][PDN_BIT:FRZ_BIT] == shd_q[MISC_ADDR][PDN_BIT:FRZ_BIT]);

   // R10: reserved bits stay zero
   assert_reserved_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (shd_q[MISC_ADDR][DIV3_BIT-1:0] == '0) && (act_q[MISC_ADDR][DIV3_BIT-1:0] == '0));

   // R11: out-of-range writes leave the staged bank untouched
   assert_oor_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (int'(wr_addr) >= NUM_REGS)) |=> $stable(shd_flat));
endmodule

// File: rtl/ctlbank_misc_decode.sv
module ctlbank_misc_decode import ctlbank_pkg::*; (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               pdn_bit,
   input  logic               cpen_bit,
   input  logic               by2_bit,
   input  logic               by3_bit,
   output logic               low_power,
   output logic               cp_mode,
   output logic [PRESC_W-1:0] prescale_div,
   output logic               prescale_chg
);
   logic [PRESC_W-1:0] div_prev_q;

   assign cp_mode      = cpen_bit;
   assign low_power    = pdn_bit & cpen_bit;
   assign prescale_div = presc_code(by2_bit, by3_bit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) div_prev_q <= PRESC_W'(1);
      else        div_prev_q <= prescale_div;
   end

   assign prescale_chg = (prescale_div != div_prev_q);
endmodule

// File: rtl/ctlbank_top.sv
module ctlbank_top import ctlbank_pkg::*; #(
   parameter int NUM_REGS  = 4,
   parameter int ADDR_W    = 3,
   parameter int MISC_ADDR = 0
)(
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [ADDR_W-1:0]          wr_addr,
   input  logic [BYTE_W-1:0]          wr_data,
   input  logic [ADDR_W-1:0]          rd_addr,
   output logic [BYTE_W-1:0]          rd_data,
   output logic [NUM_REGS*BYTE_W-1:0] ctl_q,
   output logic                       low_power,
   output logic                       cp_mode,
   output logic [PRESC_W-1:0]         prescale_div,
   output logic                       prescale_chg
);
   localparam int FLAT_W   = NUM_REGS * BYTE_W;
   localparam int MISC_LSB = MISC_ADDR * BYTE_W;

   if (NUM_REGS < 1 || NUM_REGS > (1 << ADDR_W)) begin : g_bad_depth
      $error("ctlbank_top: NUM_REGS does not fit the address width");
   end
   if (MISC_ADDR < 0 || MISC_ADDR >= NUM_REGS) begin : g_bad_misc
      $error("ctlbank_top: MISC_ADDR outside the register range");
   end

   logic [FLAT_W-1:0] shd_flat;
   logic [FLAT_W-1:0] act_flat;

   ctlbank_regfile #(
      .NUM_REGS (NUM_REGS),
      .ADDR_W   (ADDR_W),
      .MISC_ADDR(MISC_ADDR)
   ) u_regfile (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .shd_flat(shd_flat),
      .act_flat(act_flat)
   );

   ctlbank_misc_decode u_decode (
      .clk         (clk),
      .rst_n       (rst_n),
      .pdn_bit     (act_flat[MISC_LSB + PDN_BIT]),
      .cpen_bit    (act_flat[MISC_LSB + CPEN_BIT]),
      .by2_bit     (act_flat[MISC_LSB + DIV2_BIT]),
      .by3_bit     (act_flat[MISC_LSB + DIV3_BIT]),
      .low_power   (low_power),
      .cp_mode     (cp_mode),
      .prescale_div(prescale_div),
      .prescale_chg(prescale_chg)
   );

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < NUM_REGS; i++) begin
         if (rd_addr == ADDR_W'(i)) rd_data = shd_flat[i*BYTE_W +: BYTE_W];
      end
   end

   assign ctl_q = act_flat;

   // R7: low-power request only in control-port mode
   assert_lowpower_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
      low_power |-> cp_mode);

   // R9: without a change pulse the prescale selection is unchanged
   assert_chg_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !prescale_chg |-> $stable(prescale_div));
endmodule

// File: tb/test_ctlbank_top.sv
module test_ctlbank_top;
   localparam int NREG = 4;
   localparam int AW   = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [AW-1:0] rd_addr = '0;
   logic [7:0] rd_data;
   logic [NREG*8-1:0] ctl_q;
   logic low_power, cp_mode, prescale_chg;
   logic [2:0] prescale_div;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [7:0] m_shd [NREG];
   logic [7:0] m_act [NREG];
   logic [2:0] m_div;
   logic       m_chg;

   always #4 clk = ~clk;

   ctlbank_top i_ctlbank_top (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .ctl_q(ctl_q), .low_power(low_power),
      .cp_mode(cp_mode), .prescale_div(prescale_div), .prescale_chg(prescale_chg)
   );

   function automatic logic [2:0] exp_div(input logic [7:0] misc);
      if (misc[4] && misc[3]) return 3'd6;
      if (misc[4])            return 3'd2;
      if (misc[3])            return 3'd3;
      return 3'd1;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic model_step(input logic we, input logic [AW-1:0] a, input logic [7:0] d);
      logic [2:0] old_div;
      old_div = m_div;
      if (we && int'(a) < NREG) m_shd[a] = (a == 0) ? (d & 8'hF8) : d;
      if (!m_shd[0][5]) begin
         for (int i = 0; i < NREG; i++) m_act[i] = m_shd[i];
      end else begin
         m_act[0][7:5] = m_shd[0][7:5];
      end
      m_div = exp_div(m_act[0]);
      m_chg = (m_div != old_div);
   endtask

   task automatic compare_all();
      for (int i = 0; i < NREG; i++) chk("R2 live copy", 32'(ctl_q[i*8 +: 8]), 32'(m_act[i]));
      chk("R4 readback", 32'(rd_data), (int'(rd_addr) < NREG) ? 32'(m_shd[rd_addr]) : 32'd0);
      chk("R7 cp_mode", 32'(cp_mode), 32'(m_act[0][6]));
      chk("R7 low_power", 32'(low_power), 32'(m_act[0][7] & m_act[0][6]));
      chk("R8 prescale_div", 32'(prescale_div), 32'(m_div));
      chk("R9 prescale_chg", 32'(prescale_chg), 32'(m_chg));
   endtask

   task automatic cyc(input logic we, input logic [AW-1:0] a, input logic [7:0] d,
                      input logic [AW-1:0] ra);
      wr_en = we; wr_addr = a; wr_data = d; rd_addr = ra;
      @(posedge clk);
      model_step(we, a, d);
      @(negedge clk);
      compare_all();
   endtask

   function automatic logic [7:0] read_at(input logic [AW-1:0] a);
      return 8'(a);
   endfunction

   initial begin
      #(8 * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int unused_seed;
      logic [7:0] rd_tmp;
      unused_seed = $urandom(32'd20240611);
      for (int i = 0; i < NREG; i++) begin
         m_shd[i] = (i == 0) ? 8'h80 : 8'h00;
         m_act[i] = m_shd[i];
      end
      m_div = 3'd1;
      m_chg = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      for (int i = 0; i < NREG; i++) begin
         rd_addr = AW'(i);
         #1;
         chk("R1 reset readback", 32'(rd_data), (i == 0) ? 32'h80 : 32'h00);
      end
      chk("R1 reset low_power", 32'(low_power), 32'd0);
      chk("R1 reset cp_mode", 32'(cp_mode), 32'd0);
      chk("R1 reset prescale", 32'(prescale_div), 32'd1);
      @(negedge clk);

      // R7 gating by control-port enable
      cyc(1, 0, 8'h80, 0);
      chk("R7 pdn without cpen", 32'(low_power), 32'd0);
      cyc(1, 1, 8'h3C, 1);
      cyc(1, 0, 8'hC0, 0);
      chk("R7 pdn with cpen", 32'(low_power), 32'd1);
      chk("R7 contents kept in low power", 32'(ctl_q[15:8]), 32'h3C);
      cyc(1, 0, 8'h40, 0);
      chk("R7 pdn cleared", 32'(low_power), 32'd0);

      // R8 / R9 prescale selections
      cyc(1, 0, 8'h50, 0);
      chk("R8 div2", 32'(prescale_div), 32'd2);
      chk("R9 change pulse", 32'(prescale_chg), 32'd1);
      cyc(0, 0, 8'h00, 0);
      chk("R9 pulse ends", 32'(prescale_chg), 32'd0);
      cyc(1, 0, 8'h48, 0);
      chk("R8 div3", 32'(prescale_div), 32'd3);
      cyc(1, 0, 8'h58, 0);
      chk("R8 div6", 32'(prescale_div), 32'd6);
      cyc(1, 0, 8'h40, 0);
      chk("R8 undivided", 32'(prescale_div), 32'd1);

      // R10 reserved bits
      cyc(1, 0, 8'h47, 0);
      chk("R10 reserved read zero", 32'(rd_data), 32'h40);

      // R11 out-of-range address
      cyc(1, 5, 8'hFF, 6);
      chk("R11 oor read zero", 32'(rd_data), 32'h00);
      chk("R11 oor write ignored", 32'(ctl_q), {8'h00, 8'h00, 8'h3C, 8'h40});

      // R3 / R4 / R5 / R6 freeze window
      cyc(1, 0, 8'h60, 0);
      cyc(1, 1, 8'hA5, 1);
      chk("R3 general reg held", 32'(ctl_q[15:8]), 32'h3C);
      chk("R4 staged readback", 32'(rd_data), 32'hA5);
      cyc(1, 0, 8'h78, 0);
      chk("R3 divide bits held", 32'(prescale_div), 32'd1);
      cyc(1, 0, 8'hF8, 0);
      chk("R6 pdn immediate while frozen", 32'(low_power), 32'd1);
      chk("R3 divide still held", 32'(prescale_div), 32'd1);
      cyc(1, 0, 8'hD8, 1);
      chk("R5 release general reg", 32'(ctl_q[15:8]), 32'hA5);
      chk("R5 release prescale", 32'(prescale_div), 32'd6);
      chk("R5 release pulse", 32'(prescale_chg), 32'd1);
      cyc(1, 0, 8'h60, 0);
      chk("R6 freeze bit live", 32'(ctl_q[5]), 32'd1);
      cyc(1, 0, 8'h00, 0);
      chk("R6 cpen cleared while it was frozen", 32'(cp_mode), 32'd0);

      // random phase
      for (int n = 0; n < 4000; n++) begin
         logic we;
         logic [AW-1:0] a;
         logic [7:0] d;
         we = ($urandom_range(0, 9) < 7);
         a  = ($urandom_range(0, 2) == 0) ? AW'(0) : AW'($urandom_range(0, (1 << AW) - 1));
         d  = 8'($urandom());
         cyc(we, a, d, AW'($urandom_range(0, (1 << AW) - 1)));
      end
      rd_tmp = read_at(0);
      rd_addr = rd_tmp[AW-1:0];

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule